// File: doc/BRIEF.md
# Debug halt control and status register

This block is the debugger-facing halt control register of a small processor core. An external debugger reaches it over a simple 32-bit register bus. Writes to the control word carry a 16-bit key in the upper half, and a write without the key is dropped. A keyed write sets the debug enable, halt, single-step, interrupt-mask, snap-stall and counter-overflow-halt controls. The block turns these into halt-request, step and mask outputs to the core. All three outputs are gated by debug enable.

The same word returns the core's live status: halted, sleeping, locked up, and core-register transfer ready. It also returns three sticky event flags: instruction retired, reset seen, and restarted. Any read of the word clears the sticky flags. A second word holds sticky fault-cause bits that record why the core stopped. The debugger clears each of these bits by writing a one to it.

Register word index 0 is the control/status word. Index 1 is the fault word. Any other index reads as zero.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A write to the control/status word changes control state only when wdata[31:16] equals 0xA05F. A write with any other upper half leaves every control bit unchanged.
- R2: The control bits read back at bit 0 debug enable, bit 1 halt, bit 2 step, bit 3 mask, bit 5 snap-stall and bit 6 halt on counter overflow. halt_req_o, step_o and mask_o each equal their stored bit ANDed with debug enable.
- R3: The status bits sit at bit 17 halted, bit 18 sleeping and bit 19 locked up. Each reflects its core input one clock later.
- R4: Three sticky flags read at bit 24 retired, bit 25 reset seen and bit 26 restarted. A read of the control/status word returns them and then clears them. An event in the same cycle as the read keeps its flag set.
- R5: Transfer ready (bit 16) is 1 after reset. It clears on sel_wr_i and sets again on xfer_done_i.
- R6: The locked-up status reads 0 whenever core_halted_i was high in the previous cycle, even if core_lockup_i is high.
- R7: The mask bit changes only on a keyed write that sets halt to 1 while halt was already 1. Any other write leaves the mask unchanged.
- R8: When debug enable and step are set, halt is clear, and the core retires an instruction, the halt bit sets on the next clock so the core stops again.
- R9: After reset, the control/status word reads 0x0001_0000, the fault word reads 0, and all three outputs are low.
- R10: A fault bit sets on its fault_evt_i pulse and stays set. Writing 1 to a fault bit clears it, writing 0 leaves it, and a new event wins over a clear in the same cycle.
- R11: The restarted flag sets when a keyed write changes halt from 1 to 0 while the halted status reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | AW | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| sel_wr_i | input | 1 | Debugger wrote the core-register selector |
| xfer_done_i | input | 1 | Core-register transfer finished |
| core_halted_i | input | 1 | Core is in debug halt |
| core_sleep_i | input | 1 | Core is sleeping |
| core_lockup_i | input | 1 | Core is locked up |
| core_retire_i | input | 1 | Core retired an instruction this cycle |
| core_reset_i | input | 1 | Core went through reset this cycle |
| fault_evt_i | input | FW | Fault-cause event pulses |
| halt_req_o | output | 1 | Halt request to the core |
| step_o | output | 1 | Single-step enable to the core |
| mask_o | output | 1 | Interrupt mask to the core |

## Verification
The embedded properties check several rules on every cycle:

- the halted status lags core_halted_i by exactly one clock;
- a halted core forces lockup status low;
- a selector write drops transfer ready;
- an unkeyed write leaves enable, step and mask stable;
- the mask holds unless the strict halt condition is met;
- a fault event always leaves its bit set.

The directed scenarios cover the behaviour that needs a sequence of accesses:

- the exact readback words;
- the clear-on-read of the sticky flags, including the case where set wins over clear;
- the restarted flag after a halt release;
- the one-instruction step followed by a re-halt;
- the write-one-to-clear rules of the fault word.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam logic [15:0] WR_KEY = 16'hA05F;

  localparam int B_EN    = 0;
  localparam int B_HALT  = 1;
  localparam int B_STEP  = 2;
  localparam int B_MASK  = 3;
  localparam int B_SNAP  = 5;
  localparam int B_PMOV  = 6;
  localparam int B_RDY   = 16;
  localparam int B_HLTD  = 17;
  localparam int B_SLEEP = 18;
  localparam int B_LOCK  = 19;
  localparam int B_RET   = 24;
  localparam int B_RST   = 25;
  localparam int B_RSTRT = 26;

  typedef struct packed {
    logic pmov;
    logic snap;
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic restart_st;
    logic reset_st;
    logic retire_st;
    logic lockup;
    logic sleep;
    logic halted;
    logic rdy;
  } stat_t;
endpackage

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
  import dbg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        retire_i,
  input  logic        halted_i,
  output ctrl_t       ctrl_o,
  output logic        restart_o
);
  ctrl_t q;
  logic  key_wr;
  logic  unused_bits;

  assign unused_bits = ^{wdata_i[15:7], wdata_i[4]};
  assign key_wr      = wr_i && (wdata_i[31:16] == WR_KEY);
  assign restart_o   = key_wr && q.halt && !wdata_i[B_HALT] && halted_i;
  assign ctrl_o      = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (key_wr) begin
      q.en   <= wdata_i[B_EN];
      q.halt <= wdata_i[B_HALT];
      q.step <= wdata_i[B_STEP];
      q.snap <= wdata_i[B_SNAP];
      q.pmov <= wdata_i[B_PMOV];
      if (q.halt && wdata_i[B_HALT]) q.mask <= wdata_i[B_MASK];
    end else if (q.en && q.step && !q.halt && retire_i) begin
      q.halt <= 1'b1;  // step done: stop again
    end
  end

  // R1
  key_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[31:16] != WR_KEY) |=> ($stable(q.en) && $stable(q.step) && $stable(q.mask)));

  // R7
  mask_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(key_wr && q.halt && wdata_i[B_HALT]) |=> $stable(q.mask));

  // R8
  step_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && q.en && q.step && !q.halt && retire_i) |=> q.halt);
endmodule

// File: rtl/dbg_status.sv
module dbg_status
  import dbg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_i,
  input  logic  sel_wr_i,
  input  logic  xfer_done_i,
  input  logic  core_halted_i,
  input  logic  core_sleep_i,
  input  logic  core_lockup_i,
  input  logic  core_retire_i,
  input  logic  core_reset_i,
  input  logic  restart_i,
  output stat_t stat_o
);
  stat_t q;
  assign stat_o = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q     <= '0;
      q.rdy <= 1'b1;
    end else begin
      q.halted <= core_halted_i;
      q.sleep  <= core_sleep_i;
      q.lockup <= core_lockup_i && !core_halted_i;
      if (sel_wr_i)         q.rdy <= 1'b0;
      else if (xfer_done_i) q.rdy <= 1'b1;
      // set beats clear-on-read
      q.retire_st  <= core_retire_i || (q.retire_st  && !rd_i);
      q.reset_st   <= core_reset_i  || (q.reset_st   && !rd_i);
      q.restart_st <= restart_i     || (q.restart_st && !rd_i);
    end
  end

  // R3
  halted_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (q.halted == $past(core_halted_i)));

  // R6
  lockup_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_halted_i |=> !q.lockup);

  // R5
  rdy_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr_i |=> !q.rdy);

  // R4
  sticky_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !core_retire_i) |=> !q.retire_st);
endmodule

// File: rtl/dbg_fault.sv
module dbg_fault #(
  parameter int FW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [FW-1:0] wdata_i,
  input  logic [FW-1:0] evt_i,
  output logic [FW-1:0] fsr_o
);
  logic [FW-1:0] clr;
  assign clr = wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fsr_o <= '0;
    else         fsr_o <= (fsr_o & ~clr) | evt_i;
  end

  // R10
  fault_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((fsr_o & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_pkg::*;
#(
  parameter int AW      = 4,
  parameter int FW      = 5,
  parameter int CSR_IDX = 0,
  parameter int FSR_IDX = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          sel_wr_i,
  input  logic          xfer_done_i,
  input  logic          core_halted_i,
  input  logic          core_sleep_i,
  input  logic          core_lockup_i,
  input  logic          core_retire_i,
  input  logic          core_reset_i,
  input  logic [FW-1:0] fault_evt_i,
  output logic          halt_req_o,
  output logic          step_o,
  output logic          mask_o
);
  ctrl_t         ctrl;
  stat_t         stat;
  logic [FW-1:0] fsr;
  logic          csr_sel, fsr_sel, restart;

  assign csr_sel = (addr_i == AW'(CSR_IDX));
  assign fsr_sel = (addr_i == AW'(FSR_IDX));

  dbg_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (req_i && we_i && csr_sel),
    .wdata_i  (wdata_i),
    .retire_i (core_retire_i),
    .halted_i (stat.halted),
    .ctrl_o   (ctrl),
    .restart_o(restart)
  );

  dbg_status u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_i         (req_i && !we_i && csr_sel),
    .sel_wr_i     (sel_wr_i),
    .xfer_done_i  (xfer_done_i),
    .core_halted_i(core_halted_i),
    .core_sleep_i (core_sleep_i),
    .core_lockup_i(core_lockup_i),
    .core_retire_i(core_retire_i),
    .core_reset_i (core_reset_i),
    .restart_i    (restart),
    .stat_o       (stat)
  );

  dbg_fault #(.FW(FW)) u_fault (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (req_i && we_i && fsr_sel),
    .wdata_i(wdata_i[FW-1:0]),
    .evt_i  (fault_evt_i),
    .fsr_o  (fsr)
  );

  assign halt_req_o = ctrl.en && ctrl.halt;
  assign step_o     = ctrl.en && ctrl.step;
  assign mask_o     = ctrl.en && ctrl.mask;

  always_comb begin
    rdata_o = '0;
    if (csr_sel) begin
      rdata_o[B_EN]    = ctrl.en;
      rdata_o[B_HALT]  = ctrl.halt;
      rdata_o[B_STEP]  = ctrl.step;
      rdata_o[B_MASK]  = ctrl.mask;
      rdata_o[B_SNAP]  = ctrl.snap;
      rdata_o[B_PMOV]  = ctrl.pmov;
      rdata_o[B_RDY]   = stat.rdy;
      rdata_o[B_HLTD]  = stat.halted;
      rdata_o[B_SLEEP] = stat.sleep;
      rdata_o[B_LOCK]  = stat.lockup;
      rdata_o[B_RET]   = stat.retire_st;
      rdata_o[B_RST]   = stat.reset_st;
      rdata_o[B_RSTRT] = stat.restart_st;
    end else if (fsr_sel) begin
      rdata_o = 32'(fsr);
    end
  end

  // R2
  out_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en |-> !(halt_req_o || step_o || mask_o));
endmodule

// File: tb/sim_dbg_halt_ctrl.sv
module sim_dbg_halt_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int FW = 5;

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sel_wr = 0, xfer_done = 0, c_halt = 0, c_sleep = 0, c_lock = 0;
  logic c_ret = 0, c_rst = 0;
  logic [FW-1:0] evt = '0;
  logic halt_req, step, mask;
  int checks = 0, fails = 0;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_halt_ctrl #(.AW(AW), .FW(FW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sel_wr_i(sel_wr), .xfer_done_i(xfer_done),
    .core_halted_i(c_halt), .core_sleep_i(c_sleep), .core_lockup_i(c_lock),
    .core_retire_i(c_ret), .core_reset_i(c_rst), .fault_evt_i(evt),
    .halt_req_o(halt_req), .step_o(step), .mask_o(mask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    req = 1; we = 1; addr = AW'(a); wdata = d;
    tick();
    req = 0; we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    req = 1; we = 0; addr = AW'(a);
    #1 d = rdata;
    tick();
    req = 0;
  endtask

  task automatic t_reset();
    rd(0, v); chk("R9 csr reset", v, 32'h0001_0000);
    rd(1, v); chk("R9 fsr reset", v, 0);
    chk("R9 outputs", {halt_req, step, mask}, 0);
  endtask

  task automatic t_key();
    wr(0, 32'h1234_000F); rd(0, v); chk("R1 bad key", v, 32'h0001_0000);
    wr(0, 32'hA05E_0003); rd(0, v); chk("R1 near key", v, 32'h0001_0000);
  endtask

  task automatic t_gate();
    wr(0, 32'hA05F_0062); chk("R2 halt gated", halt_req, 0);
    rd(0, v); chk("R2 readback", v, 32'h0001_0062);
    wr(0, 32'hA05F_0003); chk("R2 halt req", halt_req, 1);
    rd(0, v); chk("R2 readback en", v, 32'h0001_0003);
  endtask

  task automatic t_halted();
    c_halt = 1; req = 1; we = 0; addr = 0;
    #1 chk("R3 no early halted", rdata[17], 0);
    tick(); req = 0;
    #1 chk("R3 halted after one clock", rdata[17], 1);
  endtask

  task automatic t_mask();
    wr(0, 32'hA05F_000B); chk("R7 mask accepted", mask, 1);
    wr(0, 32'hA05F_0001); chk("R7 mask kept on release", mask, 1);
    chk("R2 halt released", halt_req, 0);
    rd(0, v); chk("R11 restart set", v, 32'h0403_0009);
    rd(0, v); chk("R4 restart cleared", v, 32'h0003_0009);
    wr(0, 32'hA05F_0003); chk("R7 mask kept, halt was 0", mask, 1);
    wr(0, 32'hA05F_0003); chk("R7 mask cleared", mask, 0);
  endtask

  task automatic t_lockup();
    c_halt = 0; c_lock = 1; tick();
    rd(0, v); chk("R3 lockup", v[19], 1);
    c_halt = 1; tick();
    rd(0, v); chk("R6 lockup cleared by halt", v[19], 0);
    c_lock = 0;
  endtask

  task automatic t_sleep();
    c_sleep = 1; tick();
    rd(0, v); chk("R3 sleep", v[18], 1);
    c_sleep = 0; tick();
    rd(0, v); chk("R3 sleep off", v[18], 0);
  endtask

  task automatic t_step();
    c_halt = 0; tick();
    wr(0, 32'hA05F_0005);
    chk("R8 step out", {halt_req, step}, 2'b01);
    c_ret = 1; tick(); c_ret = 0;
    chk("R8 re-halt", halt_req, 1);
    rd(0, v); chk("R8 readback", v, 32'h0101_0007);
    rd(0, v); chk("R4 retire cleared", v, 32'h0001_0007);
  endtask

  task automatic t_sticky();
    c_rst = 1; tick(); c_rst = 0;
    rd(0, v); chk("R4 reset seen", v[25], 1);
    rd(0, v); chk("R4 reset cleared", v[25], 0);
    c_rst = 1; req = 1; we = 0; addr = 0;
    #1 chk("R4 pre-edge", rdata[25], 0);
    tick(); req = 0; c_rst = 0;
    rd(0, v); chk("R4 set beats clear", v[25], 1);
  endtask

  task automatic t_rdy();
    sel_wr = 1; tick(); sel_wr = 0;
    rd(0, v); chk("R5 rdy cleared", v[16], 0);
    xfer_done = 1; tick(); xfer_done = 0;
    rd(0, v); chk("R5 rdy set", v[16], 1);
  endtask

  task automatic t_fault();
    evt = 5'b00101; tick(); evt = 0;
    rd(1, v); chk("R10 fault set", v, 5);
    wr(1, 1); rd(1, v); chk("R10 w1c", v, 4);
    wr(1, 0); rd(1, v); chk("R10 write 0 keeps", v, 4);
    evt = 5'b00100; wr(1, 4); evt = 0;
    rd(1, v); chk("R10 set beats clear", v, 4);
    wr(1, 32'h1F); rd(1, v); chk("R10 clear all", v, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset(); t_key(); t_gate(); t_halted(); t_mask();
    t_lockup(); t_sleep(); t_step(); t_sticky(); t_rdy(); t_fault();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule